// File: doc/BRIEF.md
# Three-Level Long-Descriptor Table Walker

This block turns a 32-bit I/O virtual address into a 40-bit physical address by fetching 64-bit long-format descriptors from memory. A request carries the virtual address and a write flag on a valid/ready handshake. The table root is sampled from `tbl_base` when the request is accepted. The walker then issues one descriptor read at a time on a request/response memory port. Each read descends one level, and the walk ends at a level-2 block of 2 MB, at a level-3 page of 4 KB, or at a fault.

The result is presented for exactly one cycle. On success it gives the physical address with the access permission, access flag, shareability, attribute index, execute-never and contiguous-hint fields of the final descriptor. On failure it gives a fault code and the level at which the walk stopped. The non-secure check is applied at every level: a table entry must carry its non-secure-table bit, and a leaf must carry its non-secure bit. A set table bit does not stand in for the checks below it. Caching of results, coherency and attribute decoding belong to the surrounding logic.

Top module: `wlk_table_walker`

## Requirements
- R1: The first read of a walk goes to address {tbl_base[39:5], VA[31:30], 3'b000}, with `tbl_base` sampled when the request is accepted.
- R2: A level-2 read goes to {L1 descriptor[39:12], VA[29:21], 3'b000}, and a level-3 read goes to {L2 descriptor[39:12], VA[20:12], 3'b000}.
- R3: A level-2 descriptor whose bits [1:0] equal 01 is a 2 MB block, and the walk returns physical address {descriptor[39:21], VA[20:0]}.
- R4: A level-3 descriptor whose bits [1:0] equal 11 is a 4 KB page, and the walk returns physical address {descriptor[39:12], VA[11:0]}.
- R5: A translation fault (code 1) is reported with the current level when:
  - descriptor bit 0 is clear; or
  - a level-1 descriptor is not a table (bits [1:0] not 11); or
  - a level-3 descriptor has bits [1:0] equal to 01.
- R6: A secure-access fault (code 5) is reported with the current level when:
  - a table descriptor (bits [1:0] equal 11 at level 1 or 2) has bit 63 clear; or
  - a leaf descriptor has bit 5 clear.
- R7: A write through a leaf with bit 7 set gives a permission fault (code 4). A read through the same leaf succeeds.
- R8: A read response flagged with `mem_rsp_err` ends the walk with a walk-abort fault (code 6) at the level of that read.
- R9: On success, the outputs carry these fields of the leaf descriptor:
  - `rsp_ap` = bits 7:6
  - `rsp_af` = bit 10
  - `rsp_sh` = bits 9:8
  - `rsp_attr_idx` = bits 3:2
  - `rsp_xn` = bits 54:53
  - `rsp_contig` = bit 52
  
  The fault code and the fault level are 0.
- R10: At most one memory read is outstanding, and a walk issues at most three reads. `mem_req_addr` holds steady while `mem_req_valid` waits for `mem_req_ready`. `req_ready` is high only when no walk is in progress.
- R11: `rsp_valid` rises for a single cycle, in the cycle after the final read response is accepted. On a fault, `rsp_pa` and every attribute output are zero.
- R12: Checks on one descriptor are applied in a fixed priority:
  1. bus error
  2. translation
  3. secure access
  4. permission

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle and able to accept a request |
| req_va | input | 32 | Virtual address to translate |
| req_write | input | 1 | Request is a write access |
| tbl_base | input | 40 | Root table base address for the context |
| mem_req_valid | output | 1 | Descriptor read request |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 40 | Byte address of the descriptor |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_data | input | 64 | Descriptor value |
| mem_rsp_err | input | 1 | Bus error on this read |
| rsp_valid | output | 1 | One-cycle result strobe |
| rsp_fault | output | 1 | Walk ended in a fault |
| rsp_fault_code | output | 3 | 0 none, 1 translation, 4 permission, 5 secure access, 6 walk abort |
| rsp_fault_lvl | output | 2 | Level of the fault, or 0 on success |
| rsp_pa | output | 40 | Translated physical address |
| rsp_ap | output | 2 | Access permission field |
| rsp_af | output | 1 | Access flag |
| rsp_sh | output | 2 | Shareability field |
| rsp_attr_idx | output | 2 | Memory attribute index |
| rsp_xn | output | 2 | Execute-never field |
| rsp_contig | output | 1 | Contiguous hint |

## Verification
The properties assume that the memory side returns exactly one response for each accepted read, and never a response while no read is pending. They also assume that `req_va`, `req_write` and `tbl_base` are only relevant in the cycle of acceptance. The stimulus keeps to these assumptions:
- The bench's responder answers only after it has seen the read handshake.
- It adds a random delay before raising `mem_req_ready` and before returning data.
- It drives request fields only together with `req_valid`.

Descriptor chains are built valid, then a random bit is corrupted (bit 0, 1, 5 or 63) at a random level. Bus errors and read-only writes are mixed in at random so that every fault path and the priority between faults are reached.

// File: rtl/wlk_pkg.sv
package wlk_pkg;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_RD,
      ST_WAIT,
      ST_DONE
   } wlk_state_e;

   typedef enum logic [1:0] {
      ACT_NEXT,
      ACT_LEAF,
      ACT_FAULT
   } wlk_act_e;

   localparam logic [2:0] FC_NONE   = 3'd0;
   localparam logic [2:0] FC_XLAT   = 3'd1;
   localparam logic [2:0] FC_PERM   = 3'd4;
   localparam logic [2:0] FC_SECURE = 3'd5;
   localparam logic [2:0] FC_ABORT  = 3'd6;

   localparam logic [1:0] LVL_ROOT = 2'd1;
   localparam logic [1:0] LVL_LAST = 2'd3;

   typedef struct packed {
      logic [1:0] ap;
      logic       af;
      logic [1:0] sh;
      logic [1:0] aidx;
      logic [1:0] xn;
      logic       contig;
   } wlk_attr_t;

endpackage

// File: rtl/wlk_addr_gen.sv
module wlk_addr_gen #(
   parameter int VA_W  = 32,
   parameter int PA_W  = 40,
   parameter int GRAN  = 12,
   parameter int IDX_W = 9,
   parameter int TOP_W = 2
) (
   input  logic [1:0]         lvl,
   input  logic [PA_W-1:0]    root,
   input  logic [PA_W-1:GRAN] nxt_base,
   input  logic [VA_W-1:0]    va,
   output logic [PA_W-1:0]    addr
);
   import wlk_pkg::*;

   localparam int ENT_LG = 3;
   localparam int MID_LO = GRAN + IDX_W;

   logic [TOP_W-1:0] idx_top;
   logic [IDX_W-1:0] idx_mid;
   logic [IDX_W-1:0] idx_low;

   assign idx_top = va[VA_W-1 -: TOP_W];
   assign idx_mid = va[MID_LO +: IDX_W];
   assign idx_low = va[GRAN +: IDX_W];

   always_comb begin
      if (lvl == LVL_ROOT)
         addr = {root[PA_W-1:TOP_W+ENT_LG], idx_top, {ENT_LG{1'b0}}};
      else if (lvl == LVL_LAST)
         addr = {nxt_base, idx_low, {ENT_LG{1'b0}}};
      else
         addr = {nxt_base, idx_mid, {ENT_LG{1'b0}}};
   end
endmodule

// File: rtl/wlk_desc_dec.sv
module wlk_desc_dec #(
   parameter int VA_W       = 32,
   parameter int PA_W       = 40,
   parameter int GRAN       = 12,
   parameter int IDX_W      = 9,
   parameter int DESC_W     = 64,
   parameter bit ENFORCE_NS = 1'b1
) (
   input  logic [DESC_W-1:0]     desc,
   input  logic [1:0]            lvl,
   input  logic [VA_W-1:0]       va,
   input  logic                  wr,
   input  logic                  bus_err,
   output wlk_pkg::wlk_act_e     act,
   output logic [2:0]            code,
   output logic [PA_W-1:0]       pa,
   output wlk_pkg::wlk_attr_t    attr,
   output logic [PA_W-1:GRAN]    nxt_base
);
   import wlk_pkg::*;

   localparam int BLK_LG = GRAN + IDX_W;

   logic ns_tbl_ok;
   logic ns_leaf_ok;
   logic [PA_W-1:0] blk_pa;
   logic [PA_W-1:0] page_pa;

   generate
      if (ENFORCE_NS) begin : g_ns_on
         assign ns_tbl_ok  = desc[DESC_W-1];
         assign ns_leaf_ok = desc[5];
      end else begin : g_ns_off
         assign ns_tbl_ok  = 1'b1;
         assign ns_leaf_ok = 1'b1;
      end
   endgenerate

   assign blk_pa   = {desc[PA_W-1:BLK_LG], va[BLK_LG-1:0]};
   assign page_pa  = {desc[PA_W-1:GRAN], va[GRAN-1:0]};
   assign nxt_base = desc[PA_W-1:GRAN];

   always_comb begin
      act  = ACT_FAULT;
      code = FC_XLAT;
      pa   = '0;
      attr = '0;
      if (bus_err) begin
         code = FC_ABORT;
      end else if (!desc[0]) begin
         code = FC_XLAT;
      end else if (lvl != LVL_LAST && desc[1]) begin
         if (!ns_tbl_ok) code = FC_SECURE;
         else begin
            act  = ACT_NEXT;
            code = FC_NONE;
         end
      end else if (lvl == LVL_ROOT || (lvl == LVL_LAST && !desc[1])) begin
         code = FC_XLAT;
      end else if (!ns_leaf_ok) begin
         code = FC_SECURE;
      end else if (wr && desc[7]) begin
         code = FC_PERM;
      end else begin
         act         = ACT_LEAF;
         code        = FC_NONE;
         pa          = (lvl == LVL_LAST) ? page_pa : blk_pa;
         attr.ap     = desc[7:6];
         attr.af     = desc[10];
         attr.sh     = desc[9:8];
         attr.aidx   = desc[3:2];
         attr.xn     = desc[54:53];
         attr.contig = desc[52];
      end
   end
endmodule

// File: rtl/wlk_table_walker.sv
module wlk_table_walker #(
   parameter int VA_W       = 32,
   parameter int PA_W       = 40,
   parameter int GRAN       = 12,
   parameter int IDX_W      = 9,
   parameter int TOP_W      = 2,
   parameter int DESC_W     = 64,
   parameter bit ENFORCE_NS = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [VA_W-1:0]   req_va,
   input  logic              req_write,
   input  logic [PA_W-1:0]   tbl_base,
   output logic              mem_req_valid,
   input  logic              mem_req_ready,
   output logic [PA_W-1:0]   mem_req_addr,
   input  logic              mem_rsp_valid,
   input  logic [DESC_W-1:0] mem_rsp_data,
   input  logic              mem_rsp_err,
   output logic              rsp_valid,
   output logic              rsp_fault,
   output logic [2:0]        rsp_fault_code,
   output logic [1:0]        rsp_fault_lvl,
   output logic [PA_W-1:0]   rsp_pa,
   output logic [1:0]        rsp_ap,
   output logic              rsp_af,
   output logic [1:0]        rsp_sh,
   output logic [1:0]        rsp_attr_idx,
   output logic [1:0]        rsp_xn,
   output logic              rsp_contig
);
   import wlk_pkg::*;

   localparam int VA_SUM = GRAN + 2 * IDX_W + TOP_W;

   generate
      if (VA_SUM != VA_W) begin : g_bad_split
         $error("walker: VA_W must equal GRAN + 2*IDX_W + TOP_W");
      end
      if (IDX_W + 3 != GRAN) begin : g_bad_table
         $error("walker: a table of 64-bit entries must fill one granule");
      end
      if (DESC_W != 64 || PA_W > 48) begin : g_bad_desc
         $error("walker: descriptors are 64 bits and hold at most 48 address bits");
      end
   endgenerate

   wlk_state_e          state_q;
   logic [1:0]          lvl_q;
   logic [VA_W-1:0]     va_q;
   logic                wr_q;
   logic [PA_W-1:0]     root_q;
   logic [PA_W-1:GRAN]  base_q;
   logic [PA_W-1:0]     pa_q;
   logic [2:0]          code_q;
   logic [1:0]          flvl_q;
   wlk_attr_t           attr_q;

   wlk_act_e            dec_act;
   logic [2:0]          dec_code;
   logic [PA_W-1:0]     dec_pa;
   wlk_attr_t           dec_attr;
   logic [PA_W-1:GRAN]  dec_base;

   wlk_addr_gen #(
      .VA_W(VA_W), .PA_W(PA_W), .GRAN(GRAN), .IDX_W(IDX_W), .TOP_W(TOP_W)
   ) u_addr (
      .lvl(lvl_q), .root(root_q), .nxt_base(base_q), .va(va_q), .addr(mem_req_addr)
   );

   wlk_desc_dec #(
      .VA_W(VA_W), .PA_W(PA_W), .GRAN(GRAN), .IDX_W(IDX_W),
      .DESC_W(DESC_W), .ENFORCE_NS(ENFORCE_NS)
   ) u_dec (
      .desc(mem_rsp_data), .lvl(lvl_q), .va(va_q), .wr(wr_q), .bus_err(mem_rsp_err),
      .act(dec_act), .code(dec_code), .pa(dec_pa), .attr(dec_attr), .nxt_base(dec_base)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         lvl_q   <= LVL_ROOT;
         va_q    <= '0;
         wr_q    <= 1'b0;
         root_q  <= '0;
         base_q  <= '0;
         pa_q    <= '0;
         code_q  <= FC_NONE;
         flvl_q  <= '0;
         attr_q  <= '0;
      end else begin
         case (state_q)
            ST_IDLE: if (req_valid) begin
               va_q    <= req_va;
               wr_q    <= req_write;
               root_q  <= tbl_base;
               lvl_q   <= LVL_ROOT;
               state_q <= ST_RD;
            end
            ST_RD: if (mem_req_ready) state_q <= ST_WAIT;
            ST_WAIT: if (mem_rsp_valid) begin
               case (dec_act)
                  ACT_NEXT: begin
                     lvl_q   <= lvl_q + 2'd1;
                     base_q  <= dec_base;
                     state_q <= ST_RD;
                  end
                  ACT_LEAF: begin
                     pa_q    <= dec_pa;
                     attr_q  <= dec_attr;
                     code_q  <= FC_NONE;
                     flvl_q  <= '0;
                     state_q <= ST_DONE;
                  end
                  default: begin
                     pa_q    <= '0;
                     attr_q  <= '0;
                     code_q  <= dec_code;
                     flvl_q  <= lvl_q;
                     state_q <= ST_DONE;
                  end
               endcase
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign req_ready      = (state_q == ST_IDLE);
   assign mem_req_valid  = (state_q == ST_RD);
   assign rsp_valid      = (state_q == ST_DONE);
   assign rsp_fault      = (code_q != FC_NONE);
   assign rsp_fault_code = code_q;
   assign rsp_fault_lvl  = flvl_q;
   assign rsp_pa         = pa_q;
   assign rsp_ap         = attr_q.ap;
   assign rsp_af         = attr_q.af;
   assign rsp_sh         = attr_q.sh;
   assign rsp_attr_idx   = attr_q.aidx;
   assign rsp_xn         = attr_q.xn;
   assign rsp_contig     = attr_q.contig;
endmodule

// File: rtl/wlk_walker_chk.sv
module wlk_walker_chk #(
   parameter int PA_W = 40
) (
   input logic            clk,
   input logic            rst_n,
   input logic            req_valid,
   input logic            req_ready,
   input logic            req_write,
   input logic            mem_req_valid,
   input logic            mem_req_ready,
   input logic [PA_W-1:0] mem_req_addr,
   input logic            rsp_valid,
   input logic            rsp_fault,
   input logic [2:0]      rsp_fault_code,
   input logic [PA_W-1:0] rsp_pa,
   input logic [1:0]      rsp_ap
);
   logic [1:0] rd_cnt;
   logic       wr_seen;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_cnt  <= '0;
         wr_seen <= 1'b0;
      end else if (req_valid && req_ready) begin
         rd_cnt  <= '0;
         wr_seen <= req_write;
      end else if (mem_req_valid && mem_req_ready) begin
         rd_cnt  <= rd_cnt + 2'd1;
      end
   end

   AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr)); // R10
   AST_BUSY_NO_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid |-> !req_ready); // R10
   AST_READ_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid |-> rd_cnt < 2'd3); // R10
   AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> !rsp_valid); // R11
   AST_FAULT_ZERO_PA: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid && rsp_fault |-> rsp_pa == '0); // R11
   AST_RO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid && wr_seen && !rsp_fault |-> !rsp_ap[1]); // R7
   AST_CODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid && rsp_fault |-> (rsp_fault_code == 3'd1 || rsp_fault_code == 3'd4 ||
                                  rsp_fault_code == 3'd5 || rsp_fault_code == 3'd6)); // R5
endmodule

bind wlk_table_walker wlk_walker_chk #(.PA_W(PA_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
   .req_write(req_write), .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
   .mem_req_addr(mem_req_addr), .rsp_valid(rsp_valid), .rsp_fault(rsp_fault),
   .rsp_fault_code(rsp_fault_code), .rsp_pa(rsp_pa), .rsp_ap(rsp_ap)
);

// File: tb/tb_wlk_table_walker.sv
module tb_wlk_table_walker;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [31:0] req_va = '0;
   logic        req_write = 1'b0;
   logic [39:0] tbl_base = '0;
   logic        mem_req_valid;
   logic        mem_req_ready = 1'b0;
   logic [39:0] mem_req_addr;
   logic        mem_rsp_valid = 1'b0;
   logic [63:0] mem_rsp_data = '0;
   logic        mem_rsp_err = 1'b0;
   logic        rsp_valid, rsp_fault, rsp_af, rsp_contig;
   logic [2:0]  rsp_fault_code;
   logic [1:0]  rsp_fault_lvl, rsp_ap, rsp_sh, rsp_attr_idx, rsp_xn;
   logic [39:0] rsp_pa;

   int  n_chk = 0;
   int  n_bad = 0;
   bit  done  = 1'b0;

   always #10 clk = ~clk;

   wlk_table_walker dut (.*);

   task automatic chk(input bit ok, input string rq, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", rq, act, exp);
      end
   endtask

   function automatic string rq_of(input logic [2:0] c);
      case (c)
         3'd1: return "R5 translation fault";
         3'd4: return "R7 permission fault";
         3'd5: return "R6 secure fault";
         3'd6: return "R8 walk abort";
         default: return "R9 success";
      endcase
   endfunction

   // R12 priority: bus error, translation, secure, permission
   task automatic model(input logic [31:0] va, input bit wr, input logic [63:0] d1, d2, d3,
                        input logic [1:0] errl, output int n, output logic [2:0] code,
                        output logic [1:0] lvl, output logic [39:0] pa, output logic [10:0] at);
      logic [63:0] d;
      n = 0; code = 3'd0; lvl = 2'd0; pa = '0; at = '0;
      for (int L = 1; L <= 3; L++) begin
         d = (L == 1) ? d1 : (L == 2) ? d2 : d3;
         n = L;
         lvl = 2'(L);
         if (errl == 2'(L)) begin code = 3'd6; return; end
         if (!d[0]) begin code = 3'd1; return; end
         if (L < 3 && d[1]) begin
            if (!d[63]) begin code = 3'd5; return; end
            continue;
         end
         if (L == 1 || (L == 3 && !d[1])) begin code = 3'd1; return; end
         if (!d[5]) begin code = 3'd5; return; end
         if (wr && d[7]) begin code = 3'd4; return; end
         lvl = 2'd0;
         pa  = (L == 3) ? {d[39:12], va[11:0]} : {d[39:21], va[20:0]};
         at  = {d[7:6], d[10], d[9:8], d[3:2], d[54:53], d[52]};
         return;
      end
   endtask

   task automatic run_walk(input logic [31:0] va, input bit wr, input logic [63:0] d1, d2, d3,
                           input logic [1:0] errl);
      int n, k;
      logic [2:0]  ecode;
      logic [1:0]  elvl;
      logic [39:0] epa;
      logic [10:0] eat;
      logic [39:0] ea [1:3];
      logic [63:0] dd [1:3];
      bit extra;
      model(va, wr, d1, d2, d3, errl, n, ecode, elvl, epa, eat);
      ea[1] = {tbl_base[39:5], va[31:30], 3'b000};
      ea[2] = {d1[39:12], va[29:21], 3'b000};
      ea[3] = {d2[39:12], va[20:12], 3'b000};
      dd[1] = d1; dd[2] = d2; dd[3] = d3;
      @(negedge clk);
      chk(req_ready, "R10 ready when idle", 64'(req_ready), 64'd1);
      req_va = va; req_write = wr; req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      req_va = ~va;
      for (int L = 1; L <= n; L++) begin
         k = 0;
         while (!mem_req_valid && k < 50) begin @(negedge clk); k++; end
         if (!mem_req_valid) begin chk(1'b0, "R10 read missing", 64'd0, 64'(L)); return; end
         if (L == 1) chk(mem_req_addr == ea[L], "R1 root read address", 64'(mem_req_addr), 64'(ea[L]));
         else        chk(mem_req_addr == ea[L], "R2 next read address", 64'(mem_req_addr), 64'(ea[L]));
         chk(!req_ready, "R10 busy during walk", 64'(req_ready), 64'd0);
         repeat ($urandom % 3) begin
            @(negedge clk);
            chk(mem_req_valid && mem_req_addr == ea[L], "R10 read held", 64'(mem_req_addr), 64'(ea[L]));
         end
         mem_req_ready = 1'b1;
         @(negedge clk);
         mem_req_ready = 1'b0;
         repeat ($urandom % 3) @(negedge clk);
         mem_rsp_valid = 1'b1; mem_rsp_data = dd[L]; mem_rsp_err = (errl == 2'(L));
         @(negedge clk);
         mem_rsp_valid = 1'b0; mem_rsp_err = 1'b0;
      end
      k = 0; extra = 1'b0;
      while (!rsp_valid && k < 50) begin
         if (mem_req_valid) extra = 1'b1;
         @(negedge clk); k++;
      end
      chk(k == 0 && !extra, "R11 result timing", 64'(k), 64'd0);
      chk(rsp_fault == (ecode != 0), rq_of(ecode), 64'(rsp_fault), 64'(ecode != 0));
      chk(rsp_fault_code == ecode, rq_of(ecode), 64'(rsp_fault_code), 64'(ecode));
      chk(rsp_fault_lvl == elvl, rq_of(ecode), 64'(rsp_fault_lvl), 64'(elvl));
      chk(rsp_pa == epa, (ecode != 0) ? "R11 zero pa on fault" : (n == 2) ? "R3 block pa" : "R4 page pa",
          64'(rsp_pa), 64'(epa));
      chk({rsp_ap, rsp_af, rsp_sh, rsp_attr_idx, rsp_xn, rsp_contig} == eat, "R9 attributes",
          64'({rsp_ap, rsp_af, rsp_sh, rsp_attr_idx, rsp_xn, rsp_contig}), 64'(eat));
      @(negedge clk);
      chk(!rsp_valid, "R11 single-cycle strobe", 64'(rsp_valid), 64'd0);
   endtask

   function automatic logic [63:0] mk_tbl(input logic [63:0] x);
      return {1'b1, x[62:2], 2'b11};
   endfunction
   function automatic logic [63:0] mk_page(input logic [63:0] x);
      logic [63:0] y = x; y[1:0] = 2'b11; y[5] = 1'b1; return y;
   endfunction
   function automatic logic [63:0] mk_blk(input logic [63:0] x);
      logic [63:0] y = x; y[1:0] = 2'b01; y[5] = 1'b1; return y;
   endfunction
   function automatic logic [63:0] r64();
      return {$urandom, $urandom};
   endfunction

   initial begin
      int seed_dummy;
      seed_dummy = $urandom(32'h5eed_0042);
      repeat (3) @(negedge clk);
      chk(req_ready && !rsp_valid && !mem_req_valid, "R10 reset state",
          64'({req_ready, rsp_valid, mem_req_valid}), 64'b100);
      rst_n = 1'b1;
      tbl_base = 40'h12_3456_7800;
      // directed corners
      run_walk(32'hC123_4567, 1'b0, mk_tbl(64'hA), mk_tbl(64'h55_5550_00), mk_page(64'h0070_00AB_CDEF_0744), 2'd0); // R4 R9
      run_walk(32'h4ABC_DEF0, 1'b1, mk_tbl(64'hB000), mk_blk(64'h0010_0033_3360_0000), 64'd0, 2'd0);            // R3
      run_walk(32'h0000_1000, 1'b0, 64'h8000_0000_0000_1002, 64'd0, 64'd0, 2'd0);                               // R5 lvl1 bit0
      run_walk(32'h8000_1000, 1'b0, mk_blk(64'h1000), 64'd0, 64'd0, 2'd0);                                      // R5 lvl1 non-table
      run_walk(32'h8000_1000, 1'b0, mk_tbl(64'h1000), mk_tbl(64'h2000), mk_blk(64'h3000), 2'd0);                // R5 lvl3 01
      run_walk(32'h8000_1000, 1'b0, mk_tbl(64'h1000), mk_tbl(64'h2000) & ~(64'd1 << 63), 64'd0, 2'd0);          // R6 table
      run_walk(32'h8000_1000, 1'b0, mk_tbl(64'h1000), mk_tbl(64'h2000), mk_page(64'h3000) & ~64'h20, 2'd0);     // R6 leaf
      run_walk(32'h8000_1000, 1'b1, mk_tbl(64'h1000), mk_tbl(64'h2000), mk_page(64'h3080), 2'd0);               // R7 write
      run_walk(32'h8000_1000, 1'b0, mk_tbl(64'h1000), mk_tbl(64'h2000), mk_page(64'h3080), 2'd0);               // R7 read
      run_walk(32'h8000_1000, 1'b0, mk_tbl(64'h1000), mk_tbl(64'h2000), mk_page(64'h3000), 2'd2);               // R8
      run_walk(32'h8000_1000, 1'b0, 64'h0000_0000_0000_0002, 64'd0, 64'd0, 2'd0);                               // R12 xlat over secure
      run_walk(32'h8000_1000, 1'b1, mk_tbl(64'h1000), mk_blk(64'h2080) & ~64'h20, 64'd0, 2'd0);                 // R12 secure over perm
      run_walk(32'h8000_1000, 1'b0, 64'd0, 64'd0, 64'd0, 2'd1);                                                 // R12 abort first
      // constrained random
      for (int i = 0; i < 400; i++) begin
         logic [63:0] d [1:3];
         int   lv;
         logic [1:0] el;
         tbl_base = {r64()} & 40'hFF_FFFF_FFE0;
         d[1] = mk_tbl(r64());
         d[2] = ($urandom % 2) ? mk_tbl(r64()) : mk_blk(r64());
         d[3] = mk_page(r64());
         if ($urandom % 3 == 0) begin
            lv = 1 + $urandom % 3;
            case ($urandom % 4)
               0: d[lv][0]  = 1'b0;
               1: d[lv][1]  = ~d[lv][1];
               2: d[lv][5]  = 1'b0;
               default: d[lv][63] = 1'b0;
            endcase
         end
         el = ($urandom % 8 == 0) ? 2'(1 + $urandom % 3) : 2'd0;
         run_walk($urandom, 1'($urandom), d[1], d[2], d[3], el);
      end
      if (!done) begin
         done = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_chk++; n_bad++;
         $display("FAIL watchdog R10 actual=%h expected=%h", 64'd1, 64'd0);
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end
endmodule